// File: doc/BRIEF.md
# Dual 8/16-bit Compare Timer

This block holds two 8-bit up-counters, a high half and a low half, each paired with an 8-bit compare register. A count-enable `tick` input advances the counters. Each half raises an overflow flag when it wraps and a match flag when its count equals its compare value. Optionally, a half resets to zero on its match. A mode bit joins the two halves into one 16-bit counter. In that mode the high half advances on the low half's carry, and the high half's flags and clear-on-match report 16-bit events.

Software reaches the block through a small register bus: `bus_addr`, a one-cycle `bus_rd` or `bus_wr` strobe, write data and combinational read data. A flag can only be removed by a two-step handshake. Software first reads the flag as 1, then writes 0 to it. This keeps a blind write from discarding an event that software never saw. Each half drives a level interrupt request, formed from its overflow flag and its enable bit.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the status register, both counters and the mode bit read 0. Both compare registers read 0xFF. Both interrupt outputs are low.
- R2: Register addresses are: 0 status, 1 mode (bit 0 = 1 selects 16-bit cascade), 2 high counter, 3 low counter, 4 high compare, 5 low compare. Other addresses read 0. The status bits are 7 high overflow flag, 6 high match flag, 5 high overflow interrupt enable, 4 high clear-on-match, 3 low overflow flag, 2 low match flag, 1 low overflow interrupt enable, 0 low clear-on-match.
- R3: In 8-bit mode each half increments by one on every cycle with `tick` high, independently of the other half. With `tick` low, both halves hold.
- R4: A half's overflow flag sets when a tick moves that counter from 0xFF to 0x00.
- R5: A half's match flag sets on a tick cycle in which that counter equals its compare register.
- R6: With the low clear-on-match bit set, a matching tick loads 0 into the low counter instead of incrementing it.
- R7: In 8-bit mode, the high clear-on-match bit clears only the high counter, on the high half's own match.
- R8: In 16-bit mode the high counter advances only on a tick that wraps the low counter. The high match flag sets when {high, low} equals {high compare, low compare}. The high overflow flag sets on a wrap from 0xFFFF to 0x0000. The low flags keep reporting the low half's own events.
- R9: In 16-bit mode, the high clear-on-match bit loads 0 into both counters on a 16-bit match.
- R10: A flag clears when 0 is written to it after a status read that returned it as 1. A write of 0 without such a read leaves the flag set. Writing 1 to a flag bit has no effect. A completed clearing write disarms the flag.
- R11: When a flag's hardware set and its clearing write land in the same cycle, the flag stays set.
- R12: A bus write to a counter loads the written value in that cycle, overriding counting or clearing of that counter.
- R13: `irq_hi` is high while the high overflow flag and its enable are both 1. `irq_lo` is the same for the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tick | input | 1 | Count enable |
| irq_hi | output | 1 | High half overflow interrupt request |
| irq_lo | output | 1 | Low half overflow interrupt request |

## Verification
Counting is driven with short tick bursts near 0xFF, which separates the overflow, match and clear paths. The same bursts are repeated in cascaded mode to show that the high half moves only on the low half's carry. Flag clearing is tried in four orders: with a prior read, without one, with 1s written, and after a completed clear. These tell a proper read-then-write handshake from a blind write. Collisions are tested by putting a tick in the same cycle as a status write or a counter write. These show which side wins each conflict.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;
  localparam int ADDR_W = 3;
  localparam int HALVES = 2;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTH = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMPH = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMPL = 3'd5;

  // one status nibble per half, high half in the upper nibble
  typedef struct packed {
    logic ovf;
    logic cm;
    logic ovie;
    logic cclr;
  } half_stat_t;

  localparam int NIB_OVF  = 3;
  localparam int NIB_CM   = 2;
  localparam int NIB_OVIE = 1;
  localparam int NIB_CCLR = 0;
endpackage

// File: rtl/dct_flag_bit.sv
`timescale 1ns/1ps
module dct_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic rd_stat,
  input  logic wr_stat,
  input  logic wbit,
  output logic flag
);
  logic flag_q, flag_d, arm_q, arm_d, clr_req, upd_en;

  always_comb begin
    clr_req = wr_stat && !wbit && arm_q;
    flag_d  = set_ev || (flag_q && !clr_req);
    arm_d   = arm_q;
    if (clr_req)               arm_d = 1'b0;
    else if (rd_stat && flag_q) arm_d = 1'b1;
    upd_en  = set_ev || rd_stat || wr_stat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (upd_en) begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag = flag_q;

  AST_FLAG_KEPT_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !arm_q |=> flag_q); // R10
  AST_FLAG_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q && !set_ev |=> !flag_q); // R10
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag_q); // R11
endmodule

// File: rtl/dct_counter_pair.sv
`timescale 1ns/1ps
module dct_counter_pair #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          mode16,
  input  logic          cclr_hi,
  input  logic          cclr_lo,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] cmp_hi,
  input  logic [CW-1:0] cmp_lo,
  output logic [CW-1:0] cnt_hi,
  output logic [CW-1:0] cnt_lo,
  output logic          ev_ovf_hi,
  output logic          ev_cm_hi,
  output logic          ev_ovf_lo,
  output logic          ev_cm_lo
);
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] hi_q, lo_q, hi_d, lo_d;
  logic lo_wrap, lo_eq, hi_eq, hi_step, hi_match, hi_wrap;
  logic clr_hi, clr_lo, en_hi, en_lo;

  always_comb begin
    lo_wrap  = tick && (lo_q == TOP);
    lo_eq    = (lo_q == cmp_lo);
    hi_eq    = (hi_q == cmp_hi);
    hi_step  = mode16 ? lo_wrap : tick;
    hi_match = mode16 ? (tick && lo_eq && hi_eq) : (tick && hi_eq);
    hi_wrap  = hi_step && (hi_q == TOP);
    clr_hi   = cclr_hi && hi_match;
    clr_lo   = (mode16 && clr_hi) || (cclr_lo && tick && lo_eq);

    lo_d = lo_q;
    if (wr_lo)       lo_d = wdata;
    else if (clr_lo) lo_d = '0;
    else if (tick)   lo_d = lo_q + CW'(1);

    hi_d = hi_q;
    if (wr_hi)        hi_d = wdata;
    else if (clr_hi)  hi_d = '0;
    else if (hi_step) hi_d = hi_q + CW'(1);

    en_lo = wr_lo || clr_lo || tick;
    en_hi = wr_hi || clr_hi || hi_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (en_lo) lo_q <= lo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (en_hi) hi_q <= hi_d;
  end

  assign cnt_hi    = hi_q;
  assign cnt_lo    = lo_q;
  assign ev_ovf_lo = lo_wrap;
  assign ev_cm_lo  = tick && lo_eq;
  assign ev_ovf_hi = hi_wrap;
  assign ev_cm_hi  = hi_match;

  AST_LO_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_lo && !clr_lo |=> lo_q == $past(lo_q) + CW'(1)); // R3
  AST_HI_WAITS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    mode16 && !lo_wrap && !wr_hi && !clr_hi |=> $stable(hi_q)); // R8
  AST_LO_MATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cclr_lo && lo_eq && !wr_lo |=> lo_q == '0); // R6
  AST_BOTH_CLEAR16: assert property (@(posedge clk) disable iff (!rst_n)
    mode16 && cclr_hi && hi_match && !wr_hi && !wr_lo |=> (hi_q == '0) && (lo_q == '0)); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(wdata)); // R12
endmodule

// File: rtl/dual_cmp_timer.sv
`timescale 1ns/1ps
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [CW-1:0]     bus_wdata,
  output logic [CW-1:0]     bus_rdata,
  input  logic              tick,
  output logic              irq_hi,
  output logic              irq_lo
);
  localparam int STAT_W = HALVES * $bits(half_stat_t);

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic wr_stat, rd_stat, wr_mode, wr_cnth, wr_cntl, wr_cmph, wr_cmpl;
  always_comb begin
    wr_stat = bus_wr && (bus_addr == A_STAT);
    rd_stat = bus_rd && (bus_addr == A_STAT);
    wr_mode = bus_wr && (bus_addr == A_MODE);
    wr_cnth = bus_wr && (bus_addr == A_CNTH);
    wr_cntl = bus_wr && (bus_addr == A_CNTL);
    wr_cmph = bus_wr && (bus_addr == A_CMPH);
    wr_cmpl = bus_wr && (bus_addr == A_CMPL);
  end

  // software-owned control bits
  logic [CW-1:0]     cmp_hi_q, cmp_lo_q;
  logic              mode_q;
  logic [HALVES-1:0] ovie_q, cclr_q, ovie_d, cclr_d;

  always_comb begin
    for (int h = 0; h < HALVES; h++) begin
      ovie_d[h] = bus_wdata[4*h + NIB_OVIE];
      cclr_d[h] = bus_wdata[4*h + NIB_CCLR];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ovie_q <= '0;
      cclr_q <= '0;
    end else if (wr_stat) begin
      ovie_q <= ovie_d;
      cclr_q <= cclr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      mode_q <= 1'b0;
    else if (wr_mode) mode_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      cmp_hi_q <= '1;
    else if (wr_cmph) cmp_hi_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      cmp_lo_q <= '1;
    else if (wr_cmpl) cmp_lo_q <= bus_wdata;
  end

  logic [CW-1:0]     cnt_hi, cnt_lo;
  logic [HALVES-1:0] ev_ovf, ev_cm, ovf_q, cm_q;

  dct_counter_pair #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sn),
    .tick      (tick),
    .mode16    (mode_q),
    .cclr_hi   (cclr_q[1]),
    .cclr_lo   (cclr_q[0]),
    .wr_hi     (wr_cnth),
    .wr_lo     (wr_cntl),
    .wdata     (bus_wdata),
    .cmp_hi    (cmp_hi_q),
    .cmp_lo    (cmp_lo_q),
    .cnt_hi    (cnt_hi),
    .cnt_lo    (cnt_lo),
    .ev_ovf_hi (ev_ovf[1]),
    .ev_cm_hi  (ev_cm[1]),
    .ev_ovf_lo (ev_ovf[0]),
    .ev_cm_lo  (ev_cm[0])
  );

  half_stat_t [HALVES-1:0] stat_h;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    dct_flag_bit u_ovf (
      .clk     (clk),
      .rst_n   (rst_sn),
      .set_ev  (ev_ovf[h]),
      .rd_stat (rd_stat),
      .wr_stat (wr_stat),
      .wbit    (bus_wdata[4*h + NIB_OVF]),
      .flag    (ovf_q[h])
    );
    dct_flag_bit u_cm (
      .clk     (clk),
      .rst_n   (rst_sn),
      .set_ev  (ev_cm[h]),
      .rd_stat (rd_stat),
      .wr_stat (wr_stat),
      .wbit    (bus_wdata[4*h + NIB_CM]),
      .flag    (cm_q[h])
    );
    assign stat_h[h] = '{ovf: ovf_q[h], cm: cm_q[h], ovie: ovie_q[h], cclr: cclr_q[h]};
  end

  logic [STAT_W-1:0] stat_val;
  assign stat_val = stat_h;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT:  bus_rdata = CW'(stat_val);
      A_MODE:  bus_rdata = CW'(mode_q);
      A_CNTH:  bus_rdata = cnt_hi;
      A_CNTL:  bus_rdata = cnt_lo;
      A_CMPH:  bus_rdata = cmp_hi_q;
      A_CMPL:  bus_rdata = cmp_lo_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_hi = ovf_q[1] && ovie_q[1];
  assign irq_lo = ovf_q[0] && ovie_q[0];

  AST_IRQ_LO_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_lo && !wr_stat |=> irq_lo); // R13
  AST_IRQ_HI_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_hi && !wr_stat |=> irq_hi); // R13
  AST_STAT_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_sn)
    !wr_stat |=> $stable(ovie_q) && $stable(cclr_q)); // R2
endmodule

// File: tb/dual_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb_top;
  import dct_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tick = 1'b0;
  logic       irq_hi, irq_lo;

  always #5 clk = ~clk;

  dual_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;

  // monitor: pops one expected item per read strobe
  always @(negedge clk) begin
    if (bus_rd) begin
      item_t it;
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: actual %02h expected none", bus_rdata);
      end else begin
        it = exp_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic t = 1'b0);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick = t;
    step();
    bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    step();
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) step();
    tick = 1'b0;
  endtask

  task automatic chk_irq(input logic eh, input logic el, input string tag);
    n_cmp++;
    if (irq_hi !== eh || irq_lo !== el) begin
      n_bad++;
      $display("FAIL %s: actual hi=%b lo=%b expected hi=%b lo=%b", tag, irq_hi, irq_lo, eh, el);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();

    // R1 / R2: reset values and map
    rd(A_STAT, 8'h00, "R1 status");
    rd(A_MODE, 8'h00, "R1 mode");
    rd(A_CNTH, 8'h00, "R1 cnt hi");
    rd(A_CNTL, 8'h00, "R1 cnt lo");
    rd(A_CMPH, 8'hFF, "R1 cmp hi");
    rd(A_CMPL, 8'hFF, "R1 cmp lo");
    rd(3'd6,   8'h00, "R2 unused addr");
    chk_irq(1'b0, 1'b0, "R1 irq");

    // R3: counting and hold
    ticks(5);
    step(); step();
    rd(A_CNTL, 8'h05, "R3 lo count");
    rd(A_CNTH, 8'h05, "R3 hi count");

    // R4 / R5 / R13: low wrap, match at 0xFF, interrupt
    wr(A_CNTL, 8'hFE);
    rd(A_CNTL, 8'hFE, "R12 counter write");
    wr(A_STAT, 8'h02);
    ticks(2);
    chk_irq(1'b0, 1'b1, "R13 irq_lo up");
    rd(A_STAT, 8'h0E, "R4 R5 low flags");
    wr(A_STAT, 8'h02);
    rd(A_STAT, 8'h02, "R10 clear after read");
    chk_irq(1'b0, 1'b0, "R13 irq_lo down");

    // R10: write 0 without read, write 1, partial clear
    wr(A_CNTL, 8'hFE);
    ticks(2);
    wr(A_STAT, 8'h02);
    rd(A_STAT, 8'h0E, "R10 blind zero keeps");
    wr(A_STAT, 8'h0E);
    rd(A_STAT, 8'h0E, "R10 write one no effect");
    wr(A_STAT, 8'h06);
    rd(A_STAT, 8'h06, "R10 clear ovf only");
    wr(A_STAT, 8'h02);
    rd(A_STAT, 8'h02, "R10 clear cm");
    // R10: arm consumed by the clearing write
    wr(A_CNTL, 8'hFE);
    ticks(2);
    rd(A_STAT, 8'h0E, "R10 flags again");
    wr(A_STAT, 8'h02);
    rd(A_STAT, 8'h02, "R10 cleared");
    wr(A_CNTL, 8'hFE);
    ticks(2);
    wr(A_STAT, 8'h02);
    rd(A_STAT, 8'h0E, "R10 disarmed after clear");

    // R6: low clear on match
    wr(A_STAT, 8'h01);
    wr(A_CMPL, 8'h03);
    wr(A_CNTL, 8'h00);
    ticks(4);
    rd(A_CNTL, 8'h00, "R6 lo cleared");
    rd(A_STAT, 8'h05, "R5 R6 match flag");
    ticks(2);
    rd(A_CNTL, 8'h02, "R6 restart");
    wr(A_STAT, 8'h01);
    rd(A_STAT, 8'h01, "R10 cm clear");

    // R7: high clear on own match in 8-bit mode
    wr(A_CNTL, 8'h20);
    wr(A_CMPL, 8'h80);
    wr(A_CMPH, 8'h10);
    wr(A_CNTH, 8'h0E);
    wr(A_STAT, 8'h10);
    ticks(3);
    rd(A_CNTH, 8'h00, "R7 hi cleared");
    rd(A_CNTL, 8'h23, "R7 lo untouched");
    rd(A_STAT, 8'h50, "R7 hi match flag");
    wr(A_STAT, 8'h10);
    rd(A_STAT, 8'h10, "R10 hi cm clear");

    // R4 / R13: high overflow in 8-bit mode
    wr(A_CMPH, 8'h40);
    wr(A_CNTH, 8'hFE);
    wr(A_STAT, 8'h20);
    ticks(2);
    chk_irq(1'b1, 1'b0, "R13 irq_hi up");
    rd(A_STAT, 8'hA0, "R4 hi ovf");
    wr(A_STAT, 8'h20);
    chk_irq(1'b0, 1'b0, "R13 irq_hi down");
    rd(A_STAT, 8'h20, "R10 hi ovf clear");

    // R8: 16-bit cascade
    wr(A_MODE, 8'h01);
    rd(A_MODE, 8'h01, "R2 mode readback");
    wr(A_CMPH, 8'h01);
    wr(A_CMPL, 8'h02);
    wr(A_CNTH, 8'h00);
    wr(A_CNTL, 8'hFE);
    ticks(2);
    rd(A_CNTH, 8'h01, "R8 carry into hi");
    rd(A_CNTL, 8'h00, "R8 lo wrapped");
    rd(A_STAT, 8'h28, "R8 lo ovf only");
    ticks(2);
    rd(A_STAT, 8'h28, "R8 no match before tick");
    ticks(1);
    rd(A_STAT, 8'h6C, "R8 16-bit match");
    wr(A_STAT, 8'h20);
    rd(A_STAT, 8'h20, "R10 clear in 16-bit");
    wr(A_CNTH, 8'hFF);
    wr(A_CNTL, 8'hFE);
    ticks(2);
    chk_irq(1'b1, 1'b0, "R13 irq_hi 16-bit");
    rd(A_STAT, 8'hA8, "R8 16-bit overflow");
    rd(A_CNTH, 8'h00, "R8 hi wrapped");
    wr(A_STAT, 8'h20);

    // R9: 16-bit clear on match
    wr(A_STAT, 8'h10);
    wr(A_CNTH, 8'h01);
    wr(A_CNTL, 8'h00);
    ticks(3);
    rd(A_CNTH, 8'h00, "R9 hi cleared");
    rd(A_CNTL, 8'h00, "R9 lo cleared");
    rd(A_STAT, 8'h54, "R9 flags");
    wr(A_STAT, 8'h10);
    ticks(1);
    rd(A_CNTL, 8'h01, "R9 resumes");

    // R11: set wins against clearing write
    wr(A_MODE, 8'h00);
    wr(A_STAT, 8'h00);
    wr(A_CMPH, 8'h80);
    wr(A_CNTH, 8'h00);
    wr(A_CMPL, 8'h80);
    wr(A_CNTL, 8'hFE);
    ticks(2);
    rd(A_STAT, 8'h08, "R11 armed");
    wr(A_CNTL, 8'hFF);
    wr(A_STAT, 8'h00, 1'b1);
    rd(A_STAT, 8'h08, "R11 set wins");
    wr(A_STAT, 8'h00);
    rd(A_STAT, 8'h00, "R11 later clear");

    // R12: counter write beats tick
    wr(A_CNTL, 8'h40, 1'b1);
    rd(A_CNTL, 8'h40, "R12 write over tick");
    rd(A_CNTH, 8'h04, "R3 hi independent");

    step();
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard leftover: actual %0d expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule